// File: doc/BRIEF.md
# Saturating Element Result Clamp

This unit sits at the end of an integer vector lane and fits each element result into the destination element width. The arithmetic runs at the wider of the source and destination widths. The lane hands over that exact result with two guard bits above the operation width. When the mode field selects saturation, the unit clamps the value to the unsigned or signed limits of the destination width. It raises a per-element overflow bit in the element's condition field when a clamp took place and the condition field is being written. Any other mode wraps the result to the destination width.

Each element yields a 64-bit element value: zero-extended for unsigned clamping and for wrapping, sign-extended for signed clamping. The unit never reads or writes a sticky summary overflow bit. Instead it reports overflow only per element. Saturation combined with an overflow-enable request is flagged as an illegal instruction. Carry outputs are forced to zero whenever saturation is active. All outputs appear one clock after the inputs.

Top module: `sat_clamp_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, out_valid, out_elem, out_cr_ov, out_carry and out_illegal are all zero.
- R2: Every output reflects the inputs sampled at the previous rising clock edge, and out_valid equals in_valid delayed by one cycle.
- R3: Width codes are 0=8, 1=16, 2=32, 3=64 bits. The operation width W is the larger of the source and destination widths. The result is the two's-complement number held in in_result bits W+1 down to 0, and bits above W+1 are ignored.
- R4: Saturation is selected when in_mode[4:3] = 2'b10. With in_mode[2] = 0 (unsigned), the value is clamped to 0 .. 2^D-1, where D is the destination width, and zero-extended to 64 bits.
- R5: With saturation and in_mode[2] = 1 (signed), the value is clamped to -2^(D-1) .. 2^(D-1)-1 and sign-extended to 64 bits.
- R6: out_cr_ov is 1 exactly when saturation is selected, in_rc is 1, the instruction is legal and the value lay outside the limits. Otherwise it is 0.
- R7: For in_mode[4:3] other than 2'b10, out_elem holds the low D bits of the result, zero-extended. out_carry equals in_carry, and out_cr_ov is 0.
- R8: When saturation is selected, out_carry is 0 whatever in_carry holds.
- R9: Saturation together with in_oe = 1 sets out_illegal and forces out_elem, out_cr_ov and out_carry to 0. in_oe = 1 in any other mode does not set out_illegal.
- R10: The zeroing flags in_mode[1:0] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Element present this cycle |
| in_result | input | 66 | Exact result, two guard bits above the operation width |
| in_src_ew | input | 2 | Source element width code |
| in_dst_ew | input | 2 | Destination element width code |
| in_mode | input | 5 | Mode field: [4:3] select, [2] signed flag, [1:0] zeroing flags |
| in_rc | input | 1 | Condition field is written |
| in_oe | input | 1 | Overflow-enable request |
| in_carry | input | 2 | Carry bits from the arithmetic (full and 32-bit) |
| out_valid | output | 1 | Registered element present |
| out_elem | output | 64 | Clamped or wrapped element, extended to 64 bits |
| out_cr_ov | output | 1 | Overflow bit of the element's condition field |
| out_carry | output | 2 | Carry bits, zero under saturation |
| out_illegal | output | 1 | Saturation with overflow-enable requested |

## Verification
The bench goes after the limits themselves: values one past each bound and exactly on it, at 8 and 64 bits, in both signed and unsigned modes. An off-by-one bound or a missing sign extension would show up there as a wrong element or a spurious overflow bit. Negative results under unsigned saturation must land on zero rather than on the maximum, which a design comparing magnitudes without sign would get wrong. Cases with a wide source and a narrow destination catch a design that reads the field at the destination width and so misses overflow held in upper bits. Cases with garbage above the field catch one that reads too many bits. The remaining checks cover the overflow-enable conflict, the carry clearing and the zeroing flags. A design that kept the element on an illegal request, passed carries through or let the flags alter the result fails these.

// File: rtl/sat_clamp_pkg.sv
// Package: shared constants, width-code type and mode encoding for the
// saturating clamp unit. Assumes four element widths, doubling from 8 bits.
package sat_clamp_pkg;
    localparam int EW_CODE_W  = 2;
    localparam int EW_COUNT   = 1 << EW_CODE_W;
    localparam int MIN_ELEM_W = 8;
    localparam int MAX_ELEM_W = MIN_ELEM_W << (EW_COUNT - 1);
    localparam int GUARD_W    = 2;
    localparam int RES_W      = MAX_ELEM_W + GUARD_W;
    localparam int CARRY_W    = 2;
    localparam int MODE_W     = 5;

    typedef logic [EW_CODE_W-1:0] ew_code_t;

    typedef enum logic [1:0] {
        SEL_PLAIN  = 2'b00,
        SEL_FIRST  = 2'b01,
        SEL_SAT    = 2'b10,
        SEL_PRED   = 2'b11
    } mode_sel_e;

    // Element width in bits for a width code.
    function automatic int ew_bits(input int code);
        return MIN_ELEM_W << code;
    endfunction
endpackage

// File: rtl/sat_opwidth.sv
// Operation-width stage: picks the wider of source and destination widths
// and sign-extends the guarded field of that width to the full result bus.
// Assumes the caller places the exact result right-aligned in raw_res.
module sat_opwidth
    import sat_clamp_pkg::*;
#(
    parameter int RW = RES_W
) (
    input  ew_code_t              src_ew,
    input  ew_code_t              dst_ew,
    input  logic [RW-1:0]         raw_res,
    output ew_code_t              op_ew,
    output logic signed [RW-1:0]  op_val
);
    logic [RW-1:0] ext_by_code [EW_COUNT];

    // Choose the wider of the two element widths.
    always_comb begin
        op_ew = (src_ew > dst_ew) ? src_ew : dst_ew;
    end

    // One sign-extender per supported operation width.
    for (genvar k = 0; k < EW_COUNT; k++) begin : g_ext
        localparam int FW = ew_bits(k) + GUARD_W;
        if (FW < RW) begin : g_narrow
            assign ext_by_code[k] = {{(RW-FW){raw_res[FW-1]}}, raw_res[FW-1:0]};
        end else begin : g_full
            assign ext_by_code[k] = raw_res;
        end
    end

    // Select the extension matching the operation width.
    always_comb begin
        op_val = $signed(ext_by_code[op_ew]);
    end
endmodule

// File: rtl/sat_bounds.sv
// Limit generator: derives the upper and lower clamp bounds and the wrap
// mask for the destination width, in signed or unsigned flavour.
// Assumes the result bus is at least two bits wider than any element.
module sat_bounds
    import sat_clamp_pkg::*;
#(
    parameter int RW = RES_W
) (
    input  ew_code_t              dst_ew,
    input  logic                  signed_mode,
    output logic signed [RW-1:0]  bound_hi,
    output logic signed [RW-1:0]  bound_lo,
    output logic [RW-1:0]         wrap_mask
);
    logic [RW-1:0] u_hi_by_code [EW_COUNT];
    logic [RW-1:0] s_hi_by_code [EW_COUNT];
    logic [RW-1:0] s_lo_by_code [EW_COUNT];

    // Constant limits for each destination width.
    for (genvar k = 0; k < EW_COUNT; k++) begin : g_lim
        localparam int W = ew_bits(k);
        assign u_hi_by_code[k] = {{(RW-W){1'b0}}, {W{1'b1}}};
        assign s_hi_by_code[k] = {{(RW-W+1){1'b0}}, {(W-1){1'b1}}};
        assign s_lo_by_code[k] = {{(RW-W+1){1'b1}}, {(W-1){1'b0}}};
    end

    // Pick the limits for the requested width and signedness.
    always_comb begin
        wrap_mask = u_hi_by_code[dst_ew];
        if (signed_mode) begin
            bound_hi = $signed(s_hi_by_code[dst_ew]);
            bound_lo = $signed(s_lo_by_code[dst_ew]);
        end else begin
            bound_hi = $signed(u_hi_by_code[dst_ew]);
            bound_lo = '0;
        end
    end
endmodule

// File: rtl/sat_judge.sv
// Clamp decision: compares the operation value against the bounds, forms
// the clamped or wrapped element and reports whether a clamp happened.
// Assumes bounds already carry the correct extension in their upper bits.
module sat_judge
    import sat_clamp_pkg::*;
#(
    parameter int RW = RES_W,
    parameter int EW = MAX_ELEM_W
) (
    input  logic signed [RW-1:0] op_val,
    input  logic signed [RW-1:0] bound_hi,
    input  logic signed [RW-1:0] bound_lo,
    input  logic [RW-1:0]        wrap_mask,
    input  logic                 sat_en,
    output logic [EW-1:0]        elem,
    output logic                 clamped
);
    logic          above_hi;
    logic          below_lo;
    logic [EW-1:0] sat_val;
    logic [EW-1:0] wrap_val;

    // Signed magnitude comparison against both limits.
    always_comb begin
        above_hi = op_val > bound_hi;
        below_lo = op_val < bound_lo;
    end

    // Clamp to whichever bound was crossed, else keep the value.
    always_comb begin
        if (above_hi) begin
            sat_val = bound_hi[EW-1:0];
        end else if (below_lo) begin
            sat_val = bound_lo[EW-1:0];
        end else begin
            sat_val = op_val[EW-1:0];
        end
    end

    // Wrap to the destination width for non-saturating modes.
    always_comb begin
        wrap_val = op_val[EW-1:0] & wrap_mask[EW-1:0];
    end

    // Final element and clamp indication.
    always_comb begin
        elem    = sat_en ? sat_val : wrap_val;
        clamped = sat_en & (above_hi | below_lo);
    end
endmodule

// File: rtl/sat_clamp_unit.sv
// Top: saturating element result clamp with one register stage.
// Decodes the mode field, flags saturation with overflow-enable as illegal,
// clears carries under saturation and registers all outputs.
// Assumes the lane supplies the exact result with two guard bits.
module sat_clamp_unit
    import sat_clamp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [RES_W-1:0]      in_result,
    input  logic [EW_CODE_W-1:0]  in_src_ew,
    input  logic [EW_CODE_W-1:0]  in_dst_ew,
    input  logic [MODE_W-1:0]     in_mode,
    input  logic                  in_rc,
    input  logic                  in_oe,
    input  logic [CARRY_W-1:0]    in_carry,
    output logic                  out_valid,
    output logic [MAX_ELEM_W-1:0] out_elem,
    output logic                  out_cr_ov,
    output logic [CARRY_W-1:0]    out_carry,
    output logic                  out_illegal
);
    mode_sel_e                mode_sel;
    logic                     sat_en;
    logic                     signed_mode;
    logic                     illegal;
    logic                     unused_zero_flags;
    ew_code_t                 op_ew;
    logic signed [RES_W-1:0]  op_val;
    logic signed [RES_W-1:0]  bound_hi;
    logic signed [RES_W-1:0]  bound_lo;
    logic [RES_W-1:0]         wrap_mask;
    logic [MAX_ELEM_W-1:0]    elem;
    logic                     clamped;
    logic                     unused_op_ew;

    // Decode the mode field; zeroing flags are not used by this unit.
    always_comb begin
        mode_sel          = mode_sel_e'(in_mode[4:3]);
        sat_en            = (mode_sel == SEL_SAT);
        signed_mode       = in_mode[2];
        illegal           = sat_en & in_oe;
        unused_zero_flags = ^in_mode[1:0];
        unused_op_ew      = ^op_ew;
    end

    sat_opwidth #(.RW(RES_W)) u_opw (
        .src_ew  (in_src_ew),
        .dst_ew  (in_dst_ew),
        .raw_res (in_result),
        .op_ew   (op_ew),
        .op_val  (op_val)
    );

    sat_bounds #(.RW(RES_W)) u_bnd (
        .dst_ew      (in_dst_ew),
        .signed_mode (signed_mode),
        .bound_hi    (bound_hi),
        .bound_lo    (bound_lo),
        .wrap_mask   (wrap_mask)
    );

    sat_judge #(.RW(RES_W), .EW(MAX_ELEM_W)) u_jdg (
        .op_val    (op_val),
        .bound_hi  (bound_hi),
        .bound_lo  (bound_lo),
        .wrap_mask (wrap_mask),
        .sat_en    (sat_en),
        .elem      (elem),
        .clamped   (clamped)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_elem    <= '0;
            out_cr_ov   <= 1'b0;
            out_carry   <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_elem    <= illegal ? '0 : elem;
            out_cr_ov   <= in_rc & clamped & ~illegal;
            out_carry   <= sat_en ? '0 : in_carry;
            out_illegal <= illegal;
        end
    end
endmodule

// File: rtl/sat_clamp_chk.sv
// Checker: temporal properties of the clamp unit, bound to the top.
// Assumes the port names of sat_clamp_unit.
module sat_clamp_chk
    import sat_clamp_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [RES_W-1:0]      in_result,
    input logic [EW_CODE_W-1:0]  in_src_ew,
    input logic [EW_CODE_W-1:0]  in_dst_ew,
    input logic [MODE_W-1:0]     in_mode,
    input logic                  in_rc,
    input logic                  in_oe,
    input logic [CARRY_W-1:0]    in_carry,
    input logic                  out_valid,
    input logic [MAX_ELEM_W-1:0] out_elem,
    input logic                  out_cr_ov,
    input logic [CARRY_W-1:0]    out_carry,
    input logic                  out_illegal
);
    // R2: valid is the input valid delayed by one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R6: the overflow bit needs a written condition field
    a_r6_ov_needs_rc: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_cr_ov) |-> $past(in_rc));

    // R8: carries cleared under saturation
    a_r8_carry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_mode[4:3]) == 2'b10) |-> (out_carry == '0));

    // R9: saturation with overflow-enable is illegal and suppresses results
    a_r9_illegal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_oe) && $past(in_mode[4:3]) == 2'b10)
        |-> (out_illegal && out_elem == '0 && !out_cr_ov));

    // R4: unsigned byte saturation leaves upper bits clear
    a_r4_unsigned_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_mode[4:2]) == 3'b100 && $past(in_dst_ew) == '0)
        |-> (out_elem[MAX_ELEM_W-1:MIN_ELEM_W] == '0));
endmodule

bind sat_clamp_unit sat_clamp_chk u_chk (.*);

// File: tb/tb_sat_clamp_unit.sv
module tb_sat_clamp_unit;
    import sat_clamp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        bit          v;
        logic [63:0] e;
        bit          ov;
        logic [1:0]  ca;
        bit          ill;
        string       tag;
    } exp_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [RES_W-1:0]      in_result = '0;
    logic [EW_CODE_W-1:0]  in_src_ew = '0;
    logic [EW_CODE_W-1:0]  in_dst_ew = '0;
    logic [MODE_W-1:0]     in_mode = '0;
    logic                  in_rc = 1'b0;
    logic                  in_oe = 1'b0;
    logic [CARRY_W-1:0]    in_carry = '0;
    logic                  out_valid;
    logic [MAX_ELEM_W-1:0] out_elem;
    logic                  out_cr_ov;
    logic [CARRY_W-1:0]    out_carry;
    logic                  out_illegal;

    int   checks = 0;
    int   fails  = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_clamp_unit dut (.*);

    // Reference model written from the requirements.
    function automatic exp_t model(bit v, logic [RES_W-1:0] res, int src, int dst,
                                   logic [4:0] mode, bit rc, bit oe, logic [1:0] ca,
                                   string tag);
        exp_t r;
        int s = 8 << src;
        int d = 8 << dst;
        int w = (s > d) ? s : d;
        logic signed [67:0] val, p, hi, lo, c;
        bit sat = (mode[4:3] == 2'b10);
        bit sgn = mode[2];
        for (int i = 0; i < 68; i++) val[i] = (i < w + 2) ? res[i] : res[w+1];
        p  = 68'sd1 <<< d;
        hi = sgn ? (p >>> 1) - 68'sd1 : p - 68'sd1;
        lo = sgn ? -(p >>> 1) : 68'sd0;
        r.v = v; r.tag = tag; r.ov = 0; r.ill = 0; r.ca = 2'b00; r.e = '0;
        if (sat && oe) begin
            r.ill = 1;
        end else if (sat) begin
            c = val;
            if (val > hi) c = hi;
            else if (val < lo) c = lo;
            r.e  = c[63:0];
            r.ov = rc && (c != val);
        end else begin
            for (int i = 0; i < d; i++) r.e[i] = val[i];
            r.ca = ca;
        end
        return r;
    endfunction

    task automatic compare_head();
        exp_t x;
        if (q.size() == 0) return;
        x = q.pop_front();
        checks++;
        if (out_valid !== x.v || out_elem !== x.e || out_cr_ov !== x.ov ||
            out_carry !== x.ca || out_illegal !== x.ill) begin
            fails++;
            $display("FAIL %s: got v=%0b e=%h ov=%0b ca=%b ill=%0b, expected v=%0b e=%h ov=%0b ca=%b ill=%0b",
                     x.tag, out_valid, out_elem, out_cr_ov, out_carry, out_illegal,
                     x.v, x.e, x.ov, x.ca, x.ill);
        end
    endtask

    task automatic step(bit v, logic [RES_W-1:0] res, int src, int dst,
                        logic [4:0] mode, bit rc, bit oe, logic [1:0] ca, string tag);
        @(negedge clk);
        compare_head();
        in_valid  = v;
        in_result = res;
        in_src_ew = EW_CODE_W'(src);
        in_dst_ew = EW_CODE_W'(dst);
        in_mode   = mode;
        in_rc     = rc;
        in_oe     = oe;
        in_carry  = ca;
        q.push_back(model(v, res, src, dst, mode, rc, oe, ca, tag));
    endtask

    task automatic check_reset(string tag);
        checks++;
        if (out_valid !== 0 || out_elem !== '0 || out_cr_ov !== 0 ||
            out_carry !== '0 || out_illegal !== 0) begin
            fails++;
            $display("FAIL %s: got v=%0b e=%h ov=%0b ca=%b ill=%0b, expected all zero",
                     tag, out_valid, out_elem, out_cr_ov, out_carry, out_illegal);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got hang, expected completion");
        finish_run();
    end

    initial begin : stimulus
        logic [95:0] rnd;
        in_valid = 1'b1;
        in_mode  = 5'b10100;
        in_result = 66'h3FF;
        in_carry = 2'b11;
        repeat (3) @(negedge clk);
        check_reset("R1 during reset");
        in_valid = 1'b0; in_result = '0; in_mode = '0; in_carry = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset("R1 first cycle after reset");

        // R4 unsigned byte: above, below, inside, exact bounds
        step(1, 66'd300, 0, 0, 5'b10000, 1, 0, 2'b00, "R4 unsigned over");
        step(1, -66'sd5, 0, 0, 5'b10000, 1, 0, 2'b00, "R4 unsigned negative");
        step(1, 66'd77,  0, 0, 5'b10000, 1, 0, 2'b00, "R4 unsigned in range");
        step(1, 66'd255, 0, 0, 5'b10000, 1, 0, 2'b00, "R4 unsigned at max");
        step(1, 66'd256, 0, 0, 5'b10000, 1, 0, 2'b00, "R4 unsigned max plus one");
        // R5 signed byte
        step(1, 66'd200,   0, 0, 5'b10100, 1, 0, 2'b00, "R5 signed over");
        step(1, -66'sd200, 0, 0, 5'b10100, 1, 0, 2'b00, "R5 signed under");
        step(1, -66'sd3,   0, 0, 5'b10100, 1, 0, 2'b00, "R5 signed sign extend");
        step(1, -66'sd128, 0, 0, 5'b10100, 1, 0, 2'b00, "R5 signed at min");
        step(1, -66'sd129, 0, 0, 5'b10100, 1, 0, 2'b00, "R5 signed min minus one");
        // R3 operation width from the wider source
        step(1, 66'h1_0000_0005, 2, 0, 5'b10000, 1, 0, 2'b00, "R3 wide source overflow");
        step(1, 66'h1_0000_0005, 0, 0, 5'b10000, 1, 0, 2'b00, "R3 narrow op ignores upper");
        step(1, 66'h1000_0000_0000_0005, 1, 1, 5'b10100, 1, 0, 2'b00, "R3 garbage above field");
        step(1, 66'h0_8000, 0, 1, 5'b10100, 1, 0, 2'b00, "R3 op width from dest");
        // 64-bit limits
        step(1, 66'h1_0000_0000_0000_0000, 3, 3, 5'b10000, 1, 0, 2'b00, "R4 unsigned 64 over");
        step(1, 66'h0_8000_0000_0000_0000, 3, 3, 5'b10100, 1, 0, 2'b00, "R5 signed 64 over");
        step(1, 66'h3_7FFF_FFFF_FFFF_FFFF, 3, 3, 5'b10100, 1, 0, 2'b00, "R5 signed 64 under");
        // R6 overflow bit only with rc
        step(1, 66'd300, 0, 0, 5'b10000, 0, 0, 2'b00, "R6 clamp without rc");
        step(1, 66'd10,  0, 0, 5'b10000, 1, 0, 2'b00, "R6 no clamp with rc");
        // R7 wrap in other modes, carries pass
        step(1, 66'h1FF, 0, 0, 5'b00000, 1, 0, 2'b11, "R7 plain wrap");
        step(1, -66'sd2, 1, 1, 5'b11100, 1, 0, 2'b10, "R7 pred mode wrap");
        step(1, 66'h12345, 2, 1, 5'b01000, 1, 0, 2'b01, "R7 first mode wrap");
        // R8 carries cleared under saturation
        step(1, 66'd50, 0, 0, 5'b10000, 1, 0, 2'b11, "R8 carry cleared");
        // R9 overflow-enable conflict
        step(1, 66'd300, 0, 0, 5'b10000, 1, 1, 2'b11, "R9 sat with oe");
        step(1, 66'd300, 0, 0, 5'b00000, 1, 1, 2'b11, "R9 oe without sat");
        // R10 zeroing flags have no effect
        step(1, 66'd300, 0, 0, 5'b10011, 1, 0, 2'b00, "R10 zero flags set unsigned");
        step(1, -66'sd200, 0, 0, 5'b10110, 1, 0, 2'b00, "R10 zero flags set signed");
        step(1, 66'h1FF, 0, 0, 5'b00011, 1, 0, 2'b01, "R10 zero flags set plain");
        // R2 valid gaps
        step(0, 66'd300, 0, 0, 5'b10000, 1, 0, 2'b00, "R2 idle cycle");
        step(1, 66'd4,   0, 0, 5'b10000, 1, 0, 2'b00, "R2 after idle");
        // Mixed random patterns over all requirements
        for (int i = 0; i < 400; i++) begin
            rnd = {$urandom, $urandom, $urandom};
            if (i % 3 == 0) rnd[95:20] = {76{rnd[19]}};
            step(bit'($urandom % 8 != 0), rnd[RES_W-1:0], int'($urandom % 4), int'($urandom % 4),
                 5'($urandom), bit'($urandom), bit'($urandom % 4 == 0), 2'($urandom),
                 "R3 R4 R5 R6 R7 random");
        end
        step(0, '0, 0, 0, 5'b00000, 0, 0, 2'b00, "R2 flush");
        step(0, '0, 0, 0, 5'b00000, 0, 0, 2'b00, "R2 flush");
        finish_run();
    end
endmodule